// File: doc/BRIEF.md
# Stereo PCM Serial DAC Transmitter

This block turns stereo parallel PCM samples into a three-wire serial stream for an external audio DAC: a bit clock, a word clock that marks the channel, and one data line. Each frame carries a left and a right sample. Each sample sits in a 32-bit slot, most significant bit first, with the sample right-aligned and the upper positions filled with its sign.

Four producers can feed the block: three decoder outputs and a PCM FIFO. A 2-bit select picks one of them. Once per frame, at the frame boundary, the block raises a one-cycle ready strobe towards the selected producer. If that producer's valid is high, its sample pair goes out in the new frame. Otherwise the frame carries silence.

Before serialization each sample is scaled by an 8-bit volume value in steps of 1/256. Scale 0xFF gives unity gain and 0x00 mutes. The sample precision can be 16, 20 or 24 bits. A control input sets which word-clock level marks the left channel. The select, precision, scale and polarity, and the sample pair itself, are all sampled at the frame boundary, so no slot mixes two settings.

Top module: `pcm_dac_tx`

## Requirements
- R1: After reset `bclk` is low and toggles every HALF_DIV clock cycles. `sdata` changes only in the clock cycle where `bclk` falls. One frame lasts 64 `bclk` periods.
- R2: A frame carries the left 32-bit slot and then the right 32-bit slot, each sent most significant bit first. Each bit is valid from one falling `bclk` edge to the next.
- R3: With `lr_invert`=0, `lrclk` is low for the left channel and high for the right channel. It switches to a slot's level one `bclk` period before that slot's MSB, so it changes during the last bit of the previous slot. With `lr_invert`=1 both levels are swapped.
- R4: `prec_sel` 0 selects 16-bit samples, 1 selects 20-bit samples, and 2 or 3 select 24-bit samples. The sample is taken from the low bits of the 24-bit input, and input bits above the precision are ignored. The sample is read as two's complement and sign-extended to 32 bits.
- R5: For a scale value s from 1 to 254, the slot value is floor(v*s/256), where v is the signed sample. Scale 0xFF passes v through unchanged.
- R6: Scale 0x00 produces all-zero slots.
- R7: `src_sel` 0, 1 and 2 select decoders 0 to 2, and 3 selects the FIFO. These indices are also the bit positions in `src_valid`, `src_ready` and the 24-bit lanes of `src_left` and `src_right`. At each frame boundary only the selected bit of `src_ready` is high, for one clock cycle. If the matching valid bit is low, the frame carries zeros.
- R8: Select, precision, scale, polarity and the sample data are sampled only at the frame boundary. Changing them during a frame does not alter that frame.
- R9: During reset, `bclk`, `lrclk`, `sdata` and `src_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Source select (0 to 2 decoders, 3 FIFO) |
| prec_sel | input | 2 | Sample precision (0: 16, 1: 20, 2 or 3: 24 bits) |
| scale | input | 8 | Volume scale in 1/256 steps, 0xFF unity |
| lr_invert | input | 1 | Swap word-clock polarity |
| src_left | input | 4x24 | Left sample for each source |
| src_right | input | 4x24 | Right sample for each source |
| src_valid | input | 4 | Sample pair valid for each source |
| src_ready | output | 4 | Frame-boundary accept strobe for each source |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Word clock (channel marker) |
| sdata | output | 1 | Serial sample data, MSB first |

## Verification
A wrong bit or frame counter shows up at the ports within one frame in three ways: the `lrclk` edge lands in the wrong bit position, the ready strobe moves away from the 64-period spacing, or slot bits are misaligned. A wrong scaling or sign-extension path corrupts the upper slot bits or the value of the very next frame. Each frame is therefore compared bit by bit, for both data and word clock, against slots computed arithmetically in the bench. The sweep covers every source, every precision, a set of scale values and extreme sample values. Settings are also changed in the middle of a frame to expose any state that is not latched at the boundary.

// File: rtl/pcm_dac_pkg.sv
package pcm_dac_pkg;
    localparam int SAMPLE_W = 24;
    localparam int SLOT_W   = 32;
    localparam int FRAME_W  = 2 * SLOT_W;
    localparam int POS_W    = $clog2(FRAME_W);
    localparam int SCALE_W  = 8;
    localparam int N_SRC    = 4;
    localparam int SEL_W    = $clog2(N_SRC);
    localparam int PREC_W   = 2;
    localparam int W16      = 16;
    localparam int W20      = 20;

    typedef enum logic [PREC_W-1:0] {
        PREC_16 = 2'd0,
        PREC_20 = 2'd1,
        PREC_24 = 2'd2,
        PREC_24B = 2'd3
    } prec_e;
endpackage

// File: rtl/pcm_src_mux.sv
module pcm_src_mux
    import pcm_dac_pkg::*;
(
    input  logic [SEL_W-1:0]                sel_i,
    input  logic [N_SRC-1:0][SAMPLE_W-1:0]  left_i,
    input  logic [N_SRC-1:0][SAMPLE_W-1:0]  right_i,
    input  logic [N_SRC-1:0]                valid_i,
    input  logic                            take_i,
    output logic [SAMPLE_W-1:0]             left_o,
    output logic [SAMPLE_W-1:0]             right_o,
    output logic [N_SRC-1:0]                ready_o
);
    always_comb begin
        ready_o = take_i ? (N_SRC'(1) << sel_i) : '0;
        if (valid_i[sel_i]) begin
            left_o  = left_i[sel_i];
            right_o = right_i[sel_i];
        end else begin
            left_o  = '0;
            right_o = '0;
        end
    end
endmodule

// File: rtl/pcm_scaler.sv
module pcm_scaler
    import pcm_dac_pkg::*;
(
    input  logic [SAMPLE_W-1:0] raw_i,
    input  logic [PREC_W-1:0]   prec_i,
    input  logic [SCALE_W-1:0]  scale_i,
    output logic [SLOT_W-1:0]   slot_o
);
    localparam int PROD_W = SAMPLE_W + SCALE_W + 1;

    logic signed [SAMPLE_W-1:0] val_d;
    logic signed [SCALE_W:0]    gain_d;
    logic signed [PROD_W-1:0]   prod_d;
    logic signed [PROD_W-1:0]   shr_d;
    logic signed [SAMPLE_W-1:0] res_d;

    always_comb begin
        case (prec_e'(prec_i))
            PREC_16: val_d = SAMPLE_W'($signed(raw_i[W16-1:0]));
            PREC_20: val_d = SAMPLE_W'($signed(raw_i[W20-1:0]));
            default: val_d = $signed(raw_i);
        endcase
        gain_d = $signed({1'b0, scale_i});
        prod_d = PROD_W'(val_d) * PROD_W'(gain_d);
        shr_d  = prod_d >>> SCALE_W;
        if (scale_i == '1) res_d = val_d;
        else               res_d = SAMPLE_W'(shr_d);
        slot_o = SLOT_W'(res_d);
    end

    always_comb begin
        if (scale_i == '0) begin
            p_mute_r6: assert (slot_o == '0);
        end
        if (prec_e'(prec_i) == PREC_16) begin
            p_sign_ext_r4: assert ((&slot_o[SLOT_W-1:W16-1]) || !(|slot_o[SLOT_W-1:W16-1]));
        end
    end
endmodule

// File: rtl/pcm_serializer.sv
module pcm_serializer
    import pcm_dac_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               invert_i,
    output logic               take_o,
    output logic               bclk_o,
    output logic               lrclk_o,
    output logic               sdata_o
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0]   div;
        logic               bclk;
        logic [POS_W-1:0]   pos;
        logic [FRAME_W-1:0] sh;
        logic               sdata;
        logic               lrclk;
        logic               inv;
    } ser_t;

    ser_t st_d, st_q;
    logic [POS_W-1:0] nxt_pos_d;

    always_comb begin
        st_d      = st_q;
        take_o    = 1'b0;
        nxt_pos_d = '0;
        if (st_q.div == DIV_W'(HALF_DIV - 1)) begin
            st_d.div  = '0;
            st_d.bclk = ~st_q.bclk;
            if (st_q.bclk) begin
                st_d.pos = st_q.pos + 1'b1;
                if (st_q.pos == '1) begin
                    take_o     = 1'b1;
                    st_d.inv   = invert_i;
                    st_d.sdata = frame_i[FRAME_W-1];
                    st_d.sh    = {frame_i[FRAME_W-2:0], 1'b0};
                end else begin
                    st_d.sdata = st_q.sh[FRAME_W-1];
                    st_d.sh    = {st_q.sh[FRAME_W-2:0], 1'b0};
                end
                nxt_pos_d  = st_d.pos + 1'b1;
                st_d.lrclk = nxt_pos_d[POS_W-1] ^ st_d.inv;
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_o  = st_q.bclk;
    assign lrclk_o = st_q.lrclk;
    assign sdata_o = st_q.sdata;

    p_data_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(st_q.bclk) |-> $stable(st_q.sdata));
    p_lr_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(st_q.lrclk) |-> $fell(st_q.bclk));
    p_lr_position_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(st_q.lrclk) |-> (st_q.pos == POS_W'(SLOT_W - 1) || st_q.pos == '1 || st_q.pos == '0));
    p_take_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
endmodule

// File: rtl/pcm_dac_tx.sv
module pcm_dac_tx
    import pcm_dac_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SEL_W-1:0]               src_sel,
    input  logic [PREC_W-1:0]              prec_sel,
    input  logic [SCALE_W-1:0]             scale,
    input  logic                           lr_invert,
    input  logic [N_SRC-1:0][SAMPLE_W-1:0] src_left,
    input  logic [N_SRC-1:0][SAMPLE_W-1:0] src_right,
    input  logic [N_SRC-1:0]               src_valid,
    output logic [N_SRC-1:0]               src_ready,
    output logic                           bclk,
    output logic                           lrclk,
    output logic                           sdata
);
    logic                take;
    logic [SAMPLE_W-1:0] chan_raw [2];
    logic [SLOT_W-1:0]   chan_slot [2];
    logic [FRAME_W-1:0]  frame;

    pcm_src_mux u_mux (
        .sel_i   (src_sel),
        .left_i  (src_left),
        .right_i (src_right),
        .valid_i (src_valid),
        .take_i  (take),
        .left_o  (chan_raw[0]),
        .right_o (chan_raw[1]),
        .ready_o (src_ready)
    );

    for (genvar c = 0; c < 2; c++) begin : g_chan
        pcm_scaler u_scale (
            .raw_i   (chan_raw[c]),
            .prec_i  (prec_sel),
            .scale_i (scale),
            .slot_o  (chan_slot[c])
        );
    end

    assign frame = {chan_slot[0], chan_slot[1]};

    pcm_serializer #(.HALF_DIV(HALF_DIV)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_i  (frame),
        .invert_i (lr_invert),
        .take_o   (take),
        .bclk_o   (bclk),
        .lrclk_o  (lrclk),
        .sdata_o  (sdata)
    );

    p_ready_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ready));
    p_ready_matches_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_ready) |-> src_ready[src_sel]);
endmodule

// File: tb/tb_pcm_dac_tx.sv
module tb_pcm_dac_tx;
    localparam int HALF = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       src_sel = '0;
    logic [1:0]       prec_sel = '0;
    logic [7:0]       scale = 8'hFF;
    logic             lr_invert = 1'b0;
    logic [3:0][23:0] src_left = '0;
    logic [3:0][23:0] src_right = '0;
    logic [3:0]       src_valid = '0;
    logic [3:0]       src_ready;
    logic             bclk, lrclk, sdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pcm_dac_tx #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .prec_sel(prec_sel),
        .scale(scale), .lr_invert(lr_invert), .src_left(src_left),
        .src_right(src_right), .src_valid(src_valid), .src_ready(src_ready),
        .bclk(bclk), .lrclk(lrclk), .sdata(sdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int pw(input logic [1:0] p);
        return (p == 2'd0) ? 16 : (p == 2'd1) ? 20 : 24;
    endfunction

    function automatic logic [23:0] pick(input int k, input logic [1:0] p);
        int w = pw(p);
        logic [23:0] v;
        logic [23:0] mask = 24'((64'd1 << w) - 1);
        case (k % 6)
            0: v = mask >> 1;
            1: v = (mask >> 1) + 24'd1;
            2: v = mask;
            3: v = 24'd1;
            4: v = 24'h5A5A5A ^ 24'(k);
            default: v = 24'hA5C3E1;
        endcase
        return (v & mask) | (~mask & 24'hC3C3C3);
    endfunction

    function automatic logic [31:0] exp_slot(input logic [23:0] raw, input logic [1:0] p,
                                             input logic [7:0] s);
        int w = pw(p);
        longint v = longint'(raw & 24'((64'd1 << w) - 1));
        longint r;
        if (raw[w-1]) v = v - (longint'(1) << w);
        if (s == 8'hFF) r = v;
        else            r = (v * longint'(s)) >>> 8;
        return 32'(r);
    endfunction

    task automatic wait_take(input logic [1:0] sel);
        int n = 0;
        do begin @(negedge clk); n++; end while (src_ready == 4'b0 && n < 1000);
        chk("R7 ready one-hot on selected source", 64'(src_ready), 64'(4'b1 << sel));
    endtask

    task automatic grab(output logic [63:0] d, output logic [63:0] lr);
        for (int i = 0; i < 64; i++) begin
            @(posedge bclk); #1;
            d[63-i]  = sdata;
            lr[63-i] = lrclk;
        end
    endtask

    // Drives one configuration, optionally disturbs inputs mid-frame (R8), checks the frame.
    task automatic frame(input logic [1:0] sel, input logic [1:0] p, input logic [7:0] s,
                         input logic inv, input logic [3:0] vmask, input int k, input bit disturb);
        logic [63:0] d, lr, elr;
        logic [31:0] el, er;
        src_sel = sel; prec_sel = p; scale = s; lr_invert = inv; src_valid = vmask;
        for (int i = 0; i < 4; i++) begin
            src_left[i]  = pick(k + 2*i, p);
            src_right[i] = pick(k + 2*i + 3, p);
        end
        el = vmask[sel] ? exp_slot(src_left[sel], p, s) : 32'd0;
        er = vmask[sel] ? exp_slot(src_right[sel], p, s) : 32'd0;
        for (int q = 0; q < 64; q++) elr[63-q] = (((q + 1) % 64) >= 32) ^ inv;
        wait_take(sel);
        if (disturb) begin
            @(negedge clk);
            src_sel = sel + 2'd1; prec_sel = p + 2'd1; scale = s ^ 8'h5C;
            lr_invert = ~inv; src_left = ~src_left; src_right = ~src_right;
        end
        grab(d, lr);
        chk(disturb ? "R8 left slot unaffected by mid-frame change" :
            "R2/R4/R5 left slot", 64'(d[63:32]), 64'(el));
        chk(disturb ? "R8 right slot unaffected by mid-frame change" :
            "R2/R4/R5 right slot", 64'(d[31:0]), 64'(er));
        chk("R3 word clock pattern", lr, elr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] scl [6] = '{8'hFF, 8'h00, 8'h80, 8'h01, 8'h7F, 8'hFE};
        realtime t0, t1;
        int k = 0;
        repeat (3) @(posedge clk);
        #1;
        // R9: quiet outputs during reset
        chk("R9 reset outputs", 64'({bclk, lrclk, sdata, src_ready}), 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: bit clock period and frame length
        @(posedge bclk); t0 = $realtime;
        @(posedge bclk); t1 = $realtime;
        chk("R1 bclk period", 64'(int'(t1 - t0)), 64'(2 * HALF * 10));
        wait_take(src_sel);
        t0 = $realtime;
        wait_take(src_sel);
        t1 = $realtime;
        chk("R1 frame is 64 bclk periods", 64'(int'(t1 - t0)), 64'(64 * 2 * HALF * 10));

        // Main sweep: every source, every precision code, several scales (R4 R5 R6 R7)
        for (int sel = 0; sel < 4; sel++)
            for (int p = 0; p < 4; p++)
                for (int si = 0; si < 6; si++) begin
                    frame(2'(sel), 2'(p), scl[si], 1'b0, 4'hF, k, 1'b0);
                    k++;
                end

        // R3: inverted word clock
        frame(2'd1, 2'd2, 8'hFF, 1'b1, 4'hF, 7, 1'b0);
        frame(2'd3, 2'd0, 8'h40, 1'b1, 4'hF, 8, 1'b0);
        // R6: mute with negative extremes
        frame(2'd2, 2'd1, 8'h00, 1'b0, 4'hF, 1, 1'b0);
        // R7: selected source not valid -> silence
        frame(2'd0, 2'd2, 8'hFF, 1'b0, 4'hE, 2, 1'b0);
        frame(2'd3, 2'd0, 8'hFF, 1'b0, 4'h7, 4, 1'b0);
        // R8: mid-frame changes ignored
        frame(2'd1, 2'd0, 8'hFF, 1'b0, 4'hF, 5, 1'b1);
        frame(2'd2, 2'd2, 8'h90, 1'b1, 4'hF, 1, 1'b1);
        frame(2'd0, 2'd1, 8'h33, 1'b0, 4'hF, 0, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule